// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block is the slave-side address front end of a two-wire serial bus controller. After every START or repeated START it compares the first received byte with a programmable own address. When general-call answering is enabled, it also checks that byte for the all-zero general-call code. It raises a match flag and sets the transfer direction taken from the byte's least significant bit. It gives the ACK or NACK decision for the address byte. When a STOP ends a transfer in which the controller was addressed, it reports that STOP.

Bit sampling, byte assembly and data movement happen elsewhere. This block receives a decoded byte with a valid strobe, one-cycle START and STOP detect strobes, the own-address configuration, the general-call enable and an indication that the controller itself is currently bus master. A byte that matches neither address is NACKed. After such a byte the block stays deaf until the next STOP, including to any repeated STARTs before it.

Top module: `i2c_saddr_match`

## Requirements
- R1: After reset, and in the cycle after any cycle with `ctl_enable` low, every output is 0. While `ctl_enable` is low, START and address bytes are not acted on.
- R2: Slave addressing is enabled by `own_cfg[7]`, and `own_cfg[6:0]` holds the own address. Take the first byte after a START whose bits 7:1 equal that address, with addressing enabled. In the cycle after its `rx_valid`, `own_hit` goes to 1 and stays there, `new_match` pulses for one cycle, and `ack_valid` pulses with `ack_out` = 1.
- R3: On a match, `xmit_mode` equals bit 0 of the address byte: 1 means the slave transmits and 0 means it receives.
- R4: With `gc_enable` high, an address byte of 0x00 sets `gc_hit`, pulses `new_match`, ACKs and clears `xmit_mode`. With `gc_enable` low, the same byte (own address nonzero) is NACKed.
- R5: An address byte that matches nothing gives `ack_valid` with `ack_out` = 0 and no flag. Until the next STOP, START strobes and bytes are then ignored, and that STOP produces no `slave_stop`.
- R6: No match is reported while `own_cfg[7]` is 0 (the byte is NACKed). While `is_master` is high, an address byte gives no ACK decision and no flag.
- R7: A STOP while addressed pulses `slave_stop` for one cycle and clears `own_hit`, `gc_hit` and `xmit_mode`. A STOP while not addressed gives no `slave_stop`.
- R8: A repeated START while addressed clears the match flags. The next address byte is compared again and gives a fresh `new_match`.
- R9: Only the first byte after a START is compared. Later bytes leave every output unchanged even when they equal the own address.
- R10: When `start_det` and `stop_det` are high in the same cycle, the STOP is taken and the START is dropped: the block returns to idle and ignores the following byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Controller enable; low clears all state |
| own_cfg | input | ADDR_W+1 | Top bit enables slave addressing, lower bits hold the own address |
| gc_enable | input | 1 | Answer the general-call address 0x00 |
| is_master | input | 1 | Controller currently owns the bus as master |
| start_det | input | 1 | One-cycle strobe for START or repeated START |
| stop_det | input | 1 | One-cycle strobe for STOP |
| rx_valid | input | 1 | One-cycle strobe, a received byte is on rx_byte |
| rx_byte | input | ADDR_W+1 | Received byte, bit 0 is the read/write bit |
| own_hit | output | 1 | Own-address match flag |
| gc_hit | output | 1 | General-call match flag |
| xmit_mode | output | 1 | Slave transmit direction after a match |
| new_match | output | 1 | One-cycle event for a fresh match |
| slave_stop | output | 1 | One-cycle event for a STOP ending an addressed transfer |
| ack_valid | output | 1 | One-cycle strobe, ACK decision for the address byte |
| ack_out | output | 1 | 1 to ACK, 0 to NACK; qualified by ack_valid |

## Verification
The bench builds the block with its defaults: a 7-bit address and the general-call comparator generated in. This makes the all-zero byte reachable both as an answered general call and, once its enable is dropped, as a NACKed stranger. The bench walks the phase machine through every state change: a repeated START while addressed, deaf periods after a NACK, a STOP that collides with a START, master mode and disable. The expected flag and strobe set for every cycle is queued ahead of time and compared one cycle after the stimulus.

// File: rtl/i2c_saddr_pkg.sv
package i2c_saddr_pkg;

    // Phase of the slave front end between bus conditions.
    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,  // no address expected
        PH_WAIT_ADDR = 2'd1,  // START seen, next byte is the address
        PH_ADDRESSED = 2'd2,  // matched, transfer in progress
        PH_DEAF      = 2'd3   // NACKed, wait for STOP
    } phase_e;

    // Result of comparing one address byte.
    typedef struct packed {
        logic own;   // own address matched
        logic gc;    // general call matched
        logic rw;    // direction bit of the byte
    } verdict_t;

    // Registered outputs of the phase machine.
    typedef struct packed {
        logic own_hit;
        logic gc_hit;
        logic xmit;
        logic new_match;
        logic slave_stop;
        logic ack_valid;
        logic ack;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '0;

endpackage

// File: rtl/saddr_cmp.sv
module saddr_cmp
    import i2c_saddr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 7,
    parameter bit          GC_SUPPORT = 1'b1,
    localparam int unsigned BYTE_W    = ADDR_W + 1
) (
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic [BYTE_W-1:0] own_cfg,
    input  logic              gc_enable,
    output verdict_t          verdict
);

    logic own_match;
    logic gc_match;

    // Own address sits above the direction bit; the top config bit gates it.
    assign own_match = own_cfg[BYTE_W-1]
                     && (addr_byte[BYTE_W-1:1] == own_cfg[ADDR_W-1:0]);

    generate
        if (GC_SUPPORT) begin : g_gc
            assign gc_match = gc_enable && (addr_byte == '0);
        end else begin : g_no_gc
            logic unused_gc;
            assign unused_gc = gc_enable;
            assign gc_match  = 1'b0;
        end
    endgenerate

    always_comb begin
        verdict.own = own_match;
        verdict.gc  = gc_match && !own_match;
        verdict.rw  = addr_byte[0];
    end

endmodule

// File: rtl/saddr_phase.sv
module saddr_phase
    import i2c_saddr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ctl_enable,
    input  logic     is_master,
    input  logic     start_det,
    input  logic     stop_det,
    input  logic     rx_valid,
    input  verdict_t verdict,
    output flags_t   flags
);

    phase_e phase_q, phase_d;
    flags_t flags_q, flags_d;

    always_comb begin
        phase_d = phase_q;
        flags_d = flags_q;
        // Strobes live for one cycle only.
        flags_d.new_match  = 1'b0;
        flags_d.slave_stop = 1'b0;
        flags_d.ack_valid  = 1'b0;
        flags_d.ack        = 1'b0;

        if (!ctl_enable) begin
            phase_d = PH_IDLE;
            flags_d = FLAGS_CLEAR;
        end else if (stop_det) begin
            // STOP wins over a coincident START.
            flags_d            = FLAGS_CLEAR;
            flags_d.slave_stop = (phase_q == PH_ADDRESSED);
            phase_d            = PH_IDLE;
        end else if (start_det) begin
            if (phase_q != PH_DEAF) begin
                phase_d         = PH_WAIT_ADDR;
                flags_d.own_hit = 1'b0;
                flags_d.gc_hit  = 1'b0;
                flags_d.xmit    = 1'b0;
            end
        end else if (rx_valid && (phase_q == PH_WAIT_ADDR)) begin
            if (is_master) begin
                phase_d = PH_IDLE;
            end else if (verdict.own || verdict.gc) begin
                phase_d           = PH_ADDRESSED;
                flags_d.own_hit   = verdict.own;
                flags_d.gc_hit    = verdict.gc;
                flags_d.xmit      = verdict.own ? verdict.rw : 1'b0;
                flags_d.new_match = 1'b1;
                flags_d.ack_valid = 1'b1;
                flags_d.ack       = 1'b1;
            end else begin
                phase_d           = PH_DEAF;
                flags_d.ack_valid = 1'b1;
                flags_d.ack       = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            flags_q <= FLAGS_CLEAR;
        end else begin
            phase_q <= phase_d;
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/i2c_saddr_match.sv
module i2c_saddr_match
    import i2c_saddr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 7,
    parameter bit          GC_SUPPORT = 1'b1,
    localparam int unsigned BYTE_W    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_enable,
    input  logic [BYTE_W-1:0] own_cfg,
    input  logic              gc_enable,
    input  logic              is_master,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              own_hit,
    output logic              gc_hit,
    output logic              xmit_mode,
    output logic              new_match,
    output logic              slave_stop,
    output logic              ack_valid,
    output logic              ack_out
);

    verdict_t verdict;
    flags_t   flags;

    saddr_cmp #(
        .ADDR_W     (ADDR_W),
        .GC_SUPPORT (GC_SUPPORT)
    ) u_cmp (
        .addr_byte (rx_byte),
        .own_cfg   (own_cfg),
        .gc_enable (gc_enable),
        .verdict   (verdict)
    );

    saddr_phase u_phase (
        .clk        (clk),
        .rst        (rst),
        .ctl_enable (ctl_enable),
        .is_master  (is_master),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .rx_valid   (rx_valid),
        .verdict    (verdict),
        .flags      (flags)
    );

    assign own_hit    = flags.own_hit;
    assign gc_hit     = flags.gc_hit;
    assign xmit_mode  = flags.xmit;
    assign new_match  = flags.new_match;
    assign slave_stop = flags.slave_stop;
    assign ack_valid  = flags.ack_valid;
    assign ack_out    = flags.ack;

endmodule

// File: rtl/i2c_saddr_match_chk.sv
module i2c_saddr_match_chk (
    input logic clk,
    input logic rst,
    input logic ctl_enable,
    input logic is_master,
    input logic stop_det,
    input logic rx_valid,
    input logic own_hit,
    input logic gc_hit,
    input logic xmit_mode,
    input logic new_match,
    input logic slave_stop,
    input logic ack_valid,
    input logic ack_out
);

    assert_off_clears_R1: assert property (@(posedge clk) disable iff (rst)
        !ctl_enable |=> (!own_hit && !gc_hit && !new_match && !ack_valid));

    assert_match_from_byte_R2: assert property (@(posedge clk) disable iff (rst)
        new_match |-> ($past(rx_valid) && ack_valid && ack_out));

    assert_one_flag_R2: assert property (@(posedge clk) disable iff (rst)
        !(own_hit && gc_hit));

    assert_gc_receives_R4: assert property (@(posedge clk) disable iff (rst)
        gc_hit |-> !xmit_mode);

    assert_nack_no_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !ack_out) |-> (!own_hit && !gc_hit && !new_match));

    assert_master_silent_R6: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> !$past(is_master));

    assert_stop_after_addr_R7: assert property (@(posedge clk) disable iff (rst)
        slave_stop |-> ($past(stop_det) && $past(own_hit || gc_hit) && !own_hit && !gc_hit));

endmodule

bind i2c_saddr_match i2c_saddr_match_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_enable (ctl_enable),
    .is_master  (is_master),
    .stop_det   (stop_det),
    .rx_valid   (rx_valid),
    .own_hit    (own_hit),
    .gc_hit     (gc_hit),
    .xmit_mode  (xmit_mode),
    .new_match  (new_match),
    .slave_stop (slave_stop),
    .ack_valid  (ack_valid),
    .ack_out    (ack_out)
);

// File: tb/tb_i2c_saddr_match.sv
`timescale 1ns/1ps
module tb_i2c_saddr_match;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_enable = 1'b0;
    logic [7:0] own_cfg = 8'h00;
    logic       gc_enable = 1'b0;
    logic       is_master = 1'b0;
    logic       start_det = 1'b0;
    logic       stop_det = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic own_hit, gc_hit, xmit_mode, new_match, slave_stop, ack_valid, ack_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        logic [6:0] exp;  // {own, gc, xmit, new_match, slave_stop, ack_valid, ack}
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    i2c_saddr_match dut (
        .clk(clk), .rst(rst), .ctl_enable(ctl_enable), .own_cfg(own_cfg),
        .gc_enable(gc_enable), .is_master(is_master), .start_det(start_det),
        .stop_det(stop_det), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .own_hit(own_hit), .gc_hit(gc_hit), .xmit_mode(xmit_mode),
        .new_match(new_match), .slave_stop(slave_stop),
        .ack_valid(ack_valid), .ack_out(ack_out)
    );

    function automatic logic [6:0] outs();
        return {own_hit, gc_hit, xmit_mode, new_match, slave_stop, ack_valid, ack_out};
    endfunction

    // Driver: called at a falling edge, drives one cycle, queues the expectation.
    task automatic step(input logic st, input logic sp, input logic rv,
                        input logic [7:0] b, input logic [6:0] e, input string r);
        item_t it;
        start_det = st;
        stop_det  = sp;
        rx_valid  = rv;
        rx_byte   = b;
        it.req = r;
        it.exp = e;
        sb_q.push_back(it);
        @(negedge clk);
        start_det = 1'b0;
        stop_det  = 1'b0;
        rx_valid  = 1'b0;
    endtask

    // Monitor: compares shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (outs() !== it.exp) begin
                    errors++;
                    $display("FAIL %s: outputs %b expected %b", it.req, outs(), it.exp);
                end
            end
        end
    end

    localparam logic [6:0] Z    = 7'b0000000;
    localparam logic [6:0] OWNW = 7'b1001011;
    localparam logic [6:0] OWNR = 7'b1011011;
    localparam logic [6:0] OWNH = 7'b1000000;
    localparam logic [6:0] GCM  = 7'b0101011;
    localparam logic [6:0] NAK  = 7'b0000010;
    localparam logic [6:0] SSTP = 7'b0000100;

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (outs() !== Z) begin
            errors++;
            $display("FAIL R1: reset outputs %b expected %b", outs(), Z);
        end
        rst = 1'b0;
        ctl_enable = 1'b1;
        own_cfg = {1'b1, 7'h2A};
        gc_enable = 1'b1;

        step(0,0,0,8'h00, Z,    "R1");
        step(1,0,0,8'h00, Z,    "R2");
        step(0,0,1,8'h54, OWNW, "R2");
        step(0,0,0,8'h00, OWNH, "R2");
        step(0,0,1,8'h54, OWNH, "R9");
        step(0,1,0,8'h00, SSTP, "R7");
        step(0,0,0,8'h00, Z,    "R7");
        step(0,1,0,8'h00, Z,    "R7");
        step(1,0,0,8'h00, Z,    "R3");
        step(0,0,1,8'h55, OWNR, "R3");
        step(1,0,0,8'h00, Z,    "R8");
        step(0,0,1,8'h54, OWNW, "R8");
        step(0,1,0,8'h00, SSTP, "R7");
        step(1,0,0,8'h00, Z,    "R4");
        step(0,0,1,8'h00, GCM,  "R4");
        step(0,1,0,8'h00, SSTP, "R4");
        gc_enable = 1'b0;
        step(1,0,0,8'h00, Z,    "R4");
        step(0,0,1,8'h00, NAK,  "R4");
        step(1,0,0,8'h00, Z,    "R5");
        step(0,0,1,8'h54, Z,    "R5");
        step(0,1,0,8'h00, Z,    "R5");
        step(1,0,0,8'h00, Z,    "R5");
        step(0,0,1,8'h66, NAK,  "R5");
        step(0,1,0,8'h00, Z,    "R5");
        own_cfg = {1'b0, 7'h2A};
        step(1,0,0,8'h00, Z,    "R6");
        step(0,0,1,8'h54, NAK,  "R6");
        step(0,1,0,8'h00, Z,    "R6");
        own_cfg = {1'b1, 7'h2A};
        is_master = 1'b1;
        step(1,0,0,8'h00, Z,    "R6");
        step(0,0,1,8'h54, Z,    "R6");
        step(0,1,0,8'h00, Z,    "R6");
        is_master = 1'b0;
        step(1,0,0,8'h00, Z,    "R10");
        step(0,0,1,8'h54, OWNW, "R10");
        step(1,1,0,8'h00, SSTP, "R10");
        step(0,0,1,8'h54, Z,    "R10");
        step(1,0,0,8'h00, Z,    "R1");
        step(0,0,1,8'h55, OWNR, "R1");
        ctl_enable = 1'b0;
        step(0,0,0,8'h00, Z,    "R1");
        step(1,0,0,8'h00, Z,    "R1");
        step(0,0,1,8'h54, Z,    "R1");
        ctl_enable = 1'b1;
        step(1,0,0,8'h00, Z,    "R1");
        step(0,0,1,8'h55, OWNR, "R3");
        step(0,1,0,8'h00, SSTP, "R7");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule